// File: doc/BRIEF.md
# Hash Engine Chunk Sequencer

This controller turns a single hashing request, made of a 40-bit source address and a total length in bytes, into a series of operations for an external SHA-256 engine. It checks the request first. A zero address, a zero length or a length above the configured maximum ends the request at once with an invalid-argument status, and the engine is never touched. An accepted request first produces a one-cycle setup strobe. The setup strobe carries the engine configuration word and the total message length in bits. The block then issues one start pulse per chunk.

Every chunk except the last one is exactly `CHUNK_BYTES` long. The last chunk carries whatever is left and raises the last-buffer flag. The first operation asks the engine to load the standard initial digest. Every later operation asks the engine to continue from the intermediate digest it already holds. Between operations the block reduces the remaining-bits field.

After each start pulse the block waits for the engine's done strobe. It samples idle and the error word in that same cycle. The result decides whether the block issues the next chunk, finishes successfully or aborts the request. A wait counter bounds how long the block waits for done.

Top module: `hash_chunk_seq`

## Requirements
- R1: A request made while idle whose address is zero, whose length is zero, or whose length exceeds `MAX_LEN` produces `done_o` in the next cycle with `status`=1 (invalid). No `eng_setup` and no `eng_start` is raised for that request.
- R2: In the cycle after an accepted request, `eng_setup` is high and `eng_cfg`=4'b1101. The encoding of `eng_cfg` is: bits 1:0 = 01 selects SHA-256, bit 2 = 1 bypasses decryption, bit 3 = 1 writes the result to the hash register. `eng_msg_len` and `eng_msg_left` both equal length×8, and their upper bits are zero.
- R3: `eng_init_hash` is 1 on the first start pulse of a request and 0 on every later one.
- R4: An error-free request issues exactly ceil(length / `CHUNK_BYTES`) start pulses. The first start pulse follows `eng_setup` by one cycle. Each later start pulse follows the accepted done by one cycle.
- R5: At each start, `eng_addr_lo` is address[31:0]. `eng_hi_cnt` is {address[39:32], count}, with count in the low 24 bits. Count is `CHUNK_BYTES` while the remaining byte count is greater than one chunk. Otherwise count is the remaining byte count and `eng_last`=1.
- R6: Before each start after the first, `eng_msg_left` is reduced by `CHUNK_BYTES`×8. If it was no greater than that amount, it is set to (length mod `CHUNK_BYTES`)×8 instead.
- R7: Every start pulse comes with `eng_int_clr`=1. `eng_int_en` is 8'h1A whenever `busy` is high and 0 otherwise.
- R8: A done strobe with idle high and error word zero continues the sequence. After the last chunk, such a done leads to `done_o` with `status`=0 (ok) in the next cycle.
- R9: A done strobe with idle low aborts the request. The next cycle shows `done_o` with `status`=2 (timeout), and no further start pulse follows.
- R10: A done strobe with idle high and a non-zero error word aborts the request. The next cycle shows `done_o` with `status`=3 (engine error).
- R11: If no done strobe arrives within `TMO_CYC` cycles after a start pulse, the request aborts with `done_o` and `status`=2.
- R12: `busy` is high from setup until the final wait ends. `done_o` is a single-cycle pulse during which `busy` is low. `status` holds its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | 40 | Source address of the message |
| req_len | input | 32 | Message length in bytes |
| busy | output | 1 | A request is being sequenced |
| done_o | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 invalid, 2 timeout, 3 engine error |
| eng_setup | output | 1 | Configuration and length load strobe |
| eng_cfg | output | 4 | Engine configuration word |
| eng_msg_len | output | 64 | Total message length in bits |
| eng_msg_left | output | 64 | Message bits still to hash |
| eng_start | output | 1 | Operation kickoff pulse |
| eng_init_hash | output | 1 | 1 = start from the initial digest, 0 = continue |
| eng_last | output | 1 | Current chunk is the final buffer |
| eng_addr_lo | output | 32 | Address bits 31:0 |
| eng_hi_cnt | output | 32 | {address[39:32], chunk byte count} |
| eng_int_clr | output | 1 | Clear pending interrupt status |
| eng_int_en | output | 8 | Interrupt source enable mask |
| eng_done | input | 1 | Engine operation-done strobe |
| eng_idle | input | 1 | Engine reports idle |
| eng_err | input | 32 | Engine error status word |

## Verification
The bench builds the block with `CHUNK_BYTES`=12, `MAX_LEN`=200 and `TMO_CYC`=16. With a 12-byte chunk, a short message already splits into as many as 17 operations. Exact multiples, one-byte tails and single-chunk messages all occur within a few hundred cycles. The small length cap puts the accept/reject boundary at 200 and 201 bytes. The 16-cycle wait limit makes the no-done abort cheap to hit at any chosen operation.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ISSUE,
        ST_WAIT,
        ST_FIN
    } hcs_state_e;

    typedef enum logic [1:0] {
        HCS_OK    = 2'd0,
        HCS_INVAL = 2'd1,
        HCS_TMO   = 2'd2,
        HCS_EERR  = 2'd3
    } hcs_status_e;

    // {dst hash reg, decrypt bypass, algorithm = SHA-256}
    localparam logic [3:0] HCS_CFG_SHA256 = 4'b1101;
    localparam logic [7:0] HCS_IRQ_MASK   = 8'h1A;
endpackage

// File: rtl/hcs_req_check.sv
module hcs_req_check #(
    parameter int ADDR_W      = 40,
    parameter int LEN_W       = 32,
    parameter int MAX_LEN     = 24'hFFFFFF,
    parameter int CHUNK_BYTES = 32 * 65535
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              ok,
    output logic [LEN_W-1:0]  rem_bytes
);
    always_comb begin
        ok        = (addr != '0) && (len != '0) && (len <= LEN_W'(MAX_LEN));
        rem_bytes = len % LEN_W'(CHUNK_BYTES);
    end
endmodule

// File: rtl/hcs_chunk_plan.sv
module hcs_chunk_plan #(
    parameter int CNT_W       = 24,
    parameter int CHUNK_BYTES = 32 * 65535,
    parameter int BIT_W       = CNT_W + 3
) (
    input  logic [CNT_W-1:0] bytes_left,
    input  logic [BIT_W-1:0] left_bits,
    input  logic [BIT_W-1:0] rem_bits,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic [CNT_W-1:0] bytes_after,
    output logic [BIT_W-1:0] left_next
);
    localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK_BYTES);
    localparam logic [BIT_W-1:0] CHUNK_B = BIT_W'(CHUNK_BYTES * 8);

    always_comb begin
        last        = (bytes_left <= CHUNK_C);
        cnt         = last ? bytes_left : CHUNK_C;
        bytes_after = last ? '0 : (bytes_left - CHUNK_C);
        left_next   = (left_bits <= CHUNK_B) ? rem_bits : (left_bits - CHUNK_B);
    end
endmodule

// File: rtl/hash_chunk_seq.sv
module hash_chunk_seq
    import hcs_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int LEN_W       = 32,
    parameter int CNT_W       = 24,
    parameter int MAX_LEN     = 24'hFFFFFF,
    parameter int CHUNK_BYTES = 32 * 65535,
    parameter int TMO_CYC     = 1000000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [LEN_W-1:0]             req_len,
    output logic                         busy,
    output logic                         done_o,
    output logic [1:0]                   status,
    output logic                         eng_setup,
    output logic [3:0]                   eng_cfg,
    output logic [63:0]                  eng_msg_len,
    output logic [63:0]                  eng_msg_left,
    output logic                         eng_start,
    output logic                         eng_init_hash,
    output logic                         eng_last,
    output logic [31:0]                  eng_addr_lo,
    output logic [ADDR_W-32+CNT_W-1:0]   eng_hi_cnt,
    output logic                         eng_int_clr,
    output logic [7:0]                   eng_int_en,
    input  logic                         eng_done,
    input  logic                         eng_idle,
    input  logic [31:0]                  eng_err
);
    localparam int BIT_W = CNT_W + 3;
    localparam int TMO_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

    typedef struct packed {
        hcs_state_e        st;
        hcs_status_e       stat;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  bytes_left;
        logic [BIT_W-1:0]  total_bits;
        logic [BIT_W-1:0]  left_bits;
        logic [BIT_W-1:0]  rem_bits;
        logic              first;
        logic [TMO_W-1:0]  tmr;
    } regs_t;

    regs_t r_q, r_d;

    logic             req_ok;
    logic [LEN_W-1:0] req_rem;
    logic [CNT_W-1:0] ch_cnt, ch_bytes_after;
    logic             ch_last;
    logic [BIT_W-1:0] ch_left_next;

    hcs_req_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .CHUNK_BYTES(CHUNK_BYTES)
    ) u_check (
        .addr(req_addr), .len(req_len), .ok(req_ok), .rem_bytes(req_rem)
    );

    hcs_chunk_plan #(
        .CNT_W(CNT_W), .CHUNK_BYTES(CHUNK_BYTES), .BIT_W(BIT_W)
    ) u_plan (
        .bytes_left(r_q.bytes_left), .left_bits(r_q.left_bits), .rem_bits(r_q.rem_bits),
        .cnt(ch_cnt), .last(ch_last), .bytes_after(ch_bytes_after), .left_next(ch_left_next)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_ok) begin
                        r_d.st         = ST_SETUP;
                        r_d.stat       = HCS_OK;
                        r_d.addr       = req_addr;
                        r_d.bytes_left = req_len[CNT_W-1:0];
                        r_d.total_bits = {req_len[CNT_W-1:0], 3'b000};
                        r_d.left_bits  = {req_len[CNT_W-1:0], 3'b000};
                        r_d.rem_bits   = {req_rem[CNT_W-1:0], 3'b000};
                        r_d.first      = 1'b1;
                    end else begin
                        r_d.st   = ST_FIN;
                        r_d.stat = HCS_INVAL;
                    end
                end
            end
            ST_SETUP: r_d.st = ST_ISSUE;
            ST_ISSUE: begin
                r_d.st         = ST_WAIT;
                r_d.tmr        = '0;
                r_d.bytes_left = ch_bytes_after;
            end
            ST_WAIT: begin
                if (eng_done) begin
                    if (!eng_idle) begin
                        r_d.st   = ST_FIN;
                        r_d.stat = HCS_TMO;
                    end else if (eng_err != '0) begin
                        r_d.st   = ST_FIN;
                        r_d.stat = HCS_EERR;
                    end else if (r_q.bytes_left == '0) begin
                        r_d.st   = ST_FIN;
                        r_d.stat = HCS_OK;
                    end else begin
                        r_d.st        = ST_ISSUE;
                        r_d.first     = 1'b0;
                        r_d.left_bits = ch_left_next;
                    end
                end else if (r_q.tmr == TMO_W'(TMO_CYC - 1)) begin
                    r_d.st   = ST_FIN;
                    r_d.stat = HCS_TMO;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.stat <= HCS_OK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy          = (r_q.st == ST_SETUP) || (r_q.st == ST_ISSUE) || (r_q.st == ST_WAIT);
        done_o        = (r_q.st == ST_FIN);
        status        = r_q.stat;
        eng_setup     = (r_q.st == ST_SETUP);
        eng_cfg       = HCS_CFG_SHA256;
        eng_msg_len   = 64'(r_q.total_bits);
        eng_msg_left  = 64'(r_q.left_bits);
        eng_start     = (r_q.st == ST_ISSUE);
        eng_init_hash = r_q.first;
        eng_last      = ch_last;
        eng_addr_lo   = r_q.addr[31:0];
        eng_hi_cnt    = {r_q.addr[ADDR_W-1:32], ch_cnt};
        eng_int_clr   = eng_start;
        eng_int_en    = busy ? HCS_IRQ_MASK : 8'h00;
    end
endmodule

// File: rtl/hcs_chk.sv
module hcs_chk #(
    parameter int LEN_W       = 32,
    parameter int CNT_W       = 24,
    parameter int HC_W        = 32,
    parameter int CHUNK_BYTES = 32 * 65535
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             busy,
    input logic             done_o,
    input logic [1:0]       status,
    input logic             eng_setup,
    input logic             eng_start,
    input logic             eng_init_hash,
    input logic             eng_last,
    input logic [HC_W-1:0]  eng_hi_cnt,
    input logic             eng_int_clr,
    input logic [7:0]       eng_int_en,
    input logic             eng_done,
    input logic             eng_idle,
    input logic [31:0]      eng_err
);
    logic waiting;
    logic [CNT_W-1:0] cnt;
    assign waiting = busy && !eng_start && !eng_setup;
    assign cnt     = eng_hi_cnt[CNT_W-1:0];

    AST_REJECT_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && !done_o && (req_len == '0) |=> done_o && (status == 2'd1) && !eng_setup); // R1
    AST_SETUP_THEN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_setup |=> eng_start && eng_init_hash); // R3
    AST_LATER_NO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start && !$past(eng_setup) |-> !eng_init_hash); // R3
    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (cnt != '0) && (cnt <= CNT_W'(CHUNK_BYTES))); // R5
    AST_FULL_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start && !eng_last |-> cnt == CNT_W'(CHUNK_BYTES)); // R5
    AST_IRQ_PREP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> eng_int_clr && (eng_int_en == 8'h1A)); // R7
    AST_IDLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && eng_done && !eng_idle |=> done_o && (status == 2'd2) && !eng_start); // R9
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && eng_done && eng_idle && (eng_err != '0) |=> done_o && (status == 2'd3)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy ##1 !done_o); // R12
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R4
endmodule

bind hash_chunk_seq hcs_chk #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .HC_W(ADDR_W - 32 + CNT_W), .CHUNK_BYTES(CHUNK_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .busy(busy), .done_o(done_o), .status(status), .eng_setup(eng_setup),
    .eng_start(eng_start), .eng_init_hash(eng_init_hash), .eng_last(eng_last),
    .eng_hi_cnt(eng_hi_cnt), .eng_int_clr(eng_int_clr), .eng_int_en(eng_int_en),
    .eng_done(eng_done), .eng_idle(eng_idle), .eng_err(eng_err)
);

// File: tb/sim_hash_chunk_seq.sv
module sim_hash_chunk_seq;
    localparam int C    = 12;
    localparam int MAXL = 200;
    localparam int TMO  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic [31:0] req_len = '0;
    logic        busy, done_o, eng_setup, eng_start, eng_init_hash, eng_last, eng_int_clr;
    logic [1:0]  status;
    logic [3:0]  eng_cfg;
    logic [63:0] eng_msg_len, eng_msg_left;
    logic [31:0] eng_addr_lo, eng_hi_cnt;
    logic [7:0]  eng_int_en;
    logic        eng_done = 1'b0;
    logic        eng_idle = 1'b1;
    logic [31:0] eng_err = '0;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    hash_chunk_seq #(
        .MAX_LEN(MAXL), .CHUNK_BYTES(C), .TMO_CYC(TMO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .busy(busy), .done_o(done_o), .status(status), .eng_setup(eng_setup), .eng_cfg(eng_cfg),
        .eng_msg_len(eng_msg_len), .eng_msg_left(eng_msg_left), .eng_start(eng_start),
        .eng_init_hash(eng_init_hash), .eng_last(eng_last), .eng_addr_lo(eng_addr_lo),
        .eng_hi_cnt(eng_hi_cnt), .eng_int_clr(eng_int_clr), .eng_int_en(eng_int_en),
        .eng_done(eng_done), .eng_idle(eng_idle), .eng_err(eng_err)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", r, act, exp);
        end
    endtask

    function automatic int n_ops(input int len);
        return (len + C - 1) / C;
    endfunction

    function automatic logic [63:0] next_left(input logic [63:0] left, input int len);
        return (left <= 64'(C * 8)) ? 64'((len % C) * 8) : left - 64'(C * 8);
    endfunction

    // mode: 0 clean, 1 idle low at done, 2 error word, 3 no done
    task automatic run(input logic [39:0] a, input logic [31:0] l, input int mode,
                       input int fop, input int dly);
        bit          ok = (a != 0) && (l != 0) && (l <= MAXL);
        int          ops;
        logic [63:0] left;
        int          cnt;
        bit          fault;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok) begin
            chk("R1 done", done_o, 1);
            chk("R1 status", status, 1);
            chk("R1 no engine", {eng_setup, eng_start}, 0);
            @(negedge clk);
            chk("R12 pulse", done_o, 0);
            chk("R12 hold", status, 1);
            return;
        end
        chk("R2 setup", eng_setup, 1);
        chk("R2 cfg", eng_cfg, 4'b1101);
        chk("R2 len", eng_msg_len, 64'(l) * 8);
        chk("R2 left", eng_msg_left, 64'(l) * 8);
        chk("R12 busy", busy, 1);
        ops  = n_ops(int'(l));
        left = 64'(l) * 8;
        @(negedge clk);
        for (int i = 0; i < ops; i++) begin
            cnt = (i == ops - 1) ? int'(l) - (ops - 1) * C : C;
            chk("R4 start", eng_start, 1);
            chk("R3 init", eng_init_hash, (i == 0));
            chk("R5 last", eng_last, (i == ops - 1));
            chk("R5 hicnt", eng_hi_cnt, {a[39:32], 24'(cnt)});
            chk("R5 addrlo", eng_addr_lo, a[31:0]);
            chk("R6 left", eng_msg_left, left);
            chk("R7 irq", {eng_int_clr, eng_int_en}, {1'b1, 8'h1A});
            @(negedge clk);
            if (mode == 3 && i == fop) begin
                repeat (TMO - 1) @(negedge clk);
                chk("R11 early", done_o, 0);
                @(negedge clk);
                chk("R11 done", done_o, 1);
                chk("R11 status", status, 2);
                return;
            end
            repeat (dly) @(negedge clk);
            fault    = (mode == 1 || mode == 2) && i == fop;
            eng_done = 1'b1;
            eng_idle = !(mode == 1 && i == fop);
            eng_err  = (mode == 2 && i == fop) ? 32'h0000_0010 : 32'h0;
            @(negedge clk);
            eng_done = 1'b0; eng_idle = 1'b1; eng_err = '0;
            if (fault) begin
                chk(mode == 1 ? "R9 done" : "R10 done", done_o, 1);
                chk(mode == 1 ? "R9 status" : "R10 status", status, (mode == 1) ? 2 : 3);
                chk(mode == 1 ? "R9 no start" : "R10 no start", eng_start, 0);
                return;
            end
            if (i < ops - 1) left = next_left(left, int'(l));
        end
        chk("R8 done", done_o, 1);
        chk("R8 status", status, 0);
        chk("R12 busy low", busy, 0);
        chk("R4 no extra start", eng_start, 0);
        @(negedge clk);
        chk("R12 pulse", done_o, 0);
        chk("R12 hold", status, 0);
        chk("R7 irq off", eng_int_en, 0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset busy", busy, 0);
        chk("R12 reset done", done_o, 0);
        chk("R12 reset status", status, 0);
        chk("R4 reset start", eng_start, 0);
        // invalid requests
        run(40'h12_3456_7890, 0, 0, 0, 0);          // R1 zero length
        run(40'h0, 20, 0, 0, 0);                     // R1 zero address
        run(40'h01_0000_0000, MAXL + 1, 0, 0, 0);    // R1 just over limit
        run(40'h01_0000_0000, 32'h0100_0000, 0, 0, 0);
        // valid corner cases
        run(40'hAB_0000_1000, 1, 0, 0, 0);
        run(40'h5C_8000_0000, C, 0, 0, 1);
        run(40'h5C_8000_0000, 2 * C, 0, 0, 0);
        run(40'hFF_FFFF_FFFC, C + 1, 0, 0, 2);
        run(40'h01_0000_0004, MAXL, 0, 0, 0);
        // faults
        run(40'h33_0000_0000, 40, 1, 0, 0);          // R9
        run(40'h33_0000_0000, 40, 2, 1, 1);          // R10
        run(40'h33_0000_0000, 40, 3, 2, 0);          // R11
        run(40'h77_0000_0100, 5, 3, 0, 0);           // R11 single chunk
        // random mix
        for (int k = 0; k < 25; k++) begin
            logic [39:0] a;
            int l, m, f;
            a = {8'($urandom), $urandom};
            if (a == 0) a = 40'h1;
            l = int'($urandom_range(1, MAXL));
            m = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0;
            f = int'($urandom_range(0, n_ops(l) - 1));
            run(a, 32'(l), m, f, int'($urandom_range(0, 3)));
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule